// File: doc/BRIEF.md
# Exception Entry Control-Register Update

This block sits beside the control-register file of a small processor core. It computes and commits every control-register change that the core makes when it takes a non-break exception. On the cycle where the core raises the exception-taken strobe, the block samples several inputs:

- the current status word;
- the cause class and fault flags;
- the faulting page number and the return address;
- the fields of any external vectored interrupt request.

From these it computes, and registers on that single clock edge, the next program counter and the new values of status, the exception-saved status, the shadow-saved status, the exception return address, the page-table page number and the TLB diagnostic bits. In every other cycle all outputs hold.

What it saves depends on three things: whether an exception is already in progress (the EH bit), the requested register set compared with the current one, and the cause. Three parameters switch the MMU, the shadow register sets and the external interrupt controller in or out. When a feature is absent, its fields read 0 and its causes cannot occur.

The status word is laid out from bit 0 upward as follows: pie[0], u[1], eh[2], ih[3], il[9:4], crs[15:10], prs[21:16], nmi[22], rsie[23], srs[24]. The bits of `tlbmisc_o` are d[3], dbl[2], perm[1] and bad[0]. The cause encodings are 0 for a noninterrupt exception, 1 for an internal interrupt and 2 for an external vectored interrupt; code 3 behaves as 1. Fault flags count only with cause 0.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset, pc_o, status_o, estatus_o, sstatus_o, ea_o, pte_vpn_o and tlbmisc_o are all 0.
- R2: In a cycle where exc_i is low, no output changes, whatever the other inputs do.
- R3: Every exception entry commits status pie=0, u=0 and eh=1.
- R4: For cause 0 or 1, pc_o becomes FAST_VEC when the cause is 0 with tlb_miss_i set and the incoming eh is 0; otherwise pc_o becomes GEN_VEC.
- R5: When the incoming eh is 1, estatus_o, ea_o, pte_vpn_o and tlbmisc d/perm/bad keep their values.
- R6: For cause 0 or 1 with incoming eh 0, estatus_o takes the incoming status and ea_o takes ret_addr_i.
- R7: For cause 0 or 1 with incoming eh 0, tlbmisc d, perm and bad are set to data_acc_i, tlb_perm_i and bad_addr_i respectively (only when the cause is 0) and are cleared otherwise.
- R8: For cause 0 or 1, tlbmisc dbl is set when the cause is 0 with tlb_miss_i set and incoming eh is 1, and cleared otherwise.
- R9: For cause 0 with incoming eh 0 and either tlb_miss_i or tlb_perm_i set, pte_vpn_o takes fault_vpn_i.
- R10: For cause 2, pc_o takes eic_handler_i, and status takes ih=1, nmi=eic_nmi_i, il=eic_il_i, rsie=0, crs=eic_rrs_i and prs=the old crs.
- R11: For cause 2 with eic_rrs_i 0 and incoming eh 0, estatus_o and ea_o are saved as in R6. With eic_rrs_i nonzero, sstatus_o takes the incoming status with srs set to (eic_rrs_i != old crs), and estatus_o and ea_o are kept.
- R12: For cause 0 or 1, status fields crs, prs, ih, nmi, il, rsie and srs pass through unchanged. For cause 2, pte_vpn_o and tlbmisc_o keep their values.
- R13: With HAS_MMU, HAS_SRS and HAS_EIC all 0, status keeps only pie (forced 0), sstatus_o, pte_vpn_o and tlbmisc_o stay 0, cause 2 acts as cause 1, and pc_o is always GEN_VEC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exc_i | input | 1 | Exception-taken strobe |
| cause_i | input | 2 | Cause class |
| tlb_miss_i | input | 1 | TLB miss fault |
| tlb_perm_i | input | 1 | TLB permission fault |
| bad_addr_i | input | 1 | Bad virtual address fault |
| data_acc_i | input | 1 | Fault came from a data access |
| status_i | input | 25 | Current status word |
| fault_vpn_i | input | VPN_W | Page number of the faulting address |
| ret_addr_i | input | ADDR_W | Address of the next instruction |
| eic_handler_i | input | ADDR_W | Handler address of external request |
| eic_rrs_i | input | 6 | Requested register set |
| eic_nmi_i | input | 1 | External request is nonmaskable |
| eic_il_i | input | 6 | External request level |
| pc_o | output | ADDR_W | Next program counter |
| status_o | output | 25 | Status after entry |
| estatus_o | output | 25 | Exception-saved status |
| sstatus_o | output | 25 | Shadow-saved status |
| ea_o | output | ADDR_W | Exception return address |
| pte_vpn_o | output | VPN_W | Page-table page number |
| tlbmisc_o | output | 4 | TLB diagnostic bits |

## Verification
The bench builds two instances side by side. The first has the MMU, the shadow sets and the external controller all present. The second has none of them, so that the constant-zero fields and the collapse of cause 2 into cause 1 are observed on the same stimulus.

The bench sweeps every combination of the following:

- the incoming eh bit;
- the three cause classes;
- all sixteen fault-flag patterns;
- a requested register set that is zero, equal to the current set, or different from it;
- four current-set values.

This covers nested double misses, shadow saves with and without srs, and ext entries that save estatus. Each entry is followed by an idle cycle with scrambled inputs to confirm that the outputs hold.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int RS_W = 6;
  localparam int IL_W = 6;

  typedef struct packed {
    logic            srs;
    logic            rsie;
    logic            nmi;
    logic [RS_W-1:0] prs;
    logic [RS_W-1:0] crs;
    logic [IL_W-1:0] il;
    logic            ih;
    logic            eh;
    logic            u;
    logic            pie;
  } stat_t;

  localparam int STAT_W = $bits(stat_t);

  localparam logic [1:0] CAUSE_EXC = 2'd0;
  localparam logic [1:0] CAUSE_IRQ = 2'd1;
  localparam logic [1:0] CAUSE_EXT = 2'd2;

  // tlbmisc bit positions
  localparam int TM_BAD  = 0;
  localparam int TM_PERM = 1;
  localparam int TM_DBL  = 2;
  localparam int TM_D    = 3;

  function automatic stat_t strip_stat(stat_t s, bit mmu, bit srs, bit eic);
    stat_t r;
    r = s;
    if (!mmu) begin
      r.eh = 1'b0;
      r.u  = 1'b0;
    end
    if (!srs) begin
      r.crs  = '0;
      r.prs  = '0;
      r.rsie = 1'b0;
      r.srs  = 1'b0;
    end
    if (!eic) begin
      r.ih  = 1'b0;
      r.nmi = 1'b0;
      r.il  = '0;
    end
    return r;
  endfunction
endpackage

// File: rtl/exc_cause_decode.sv
module exc_cause_decode
  import exc_pkg::*;
#(
  parameter bit HAS_MMU = 1'b1,
  parameter bit HAS_EIC = 1'b1
) (
  input  logic [1:0] cause_i,
  input  logic       eh_i,
  input  logic       miss_i,
  input  logic       perm_i,
  input  logic       bad_i,
  input  logic       dacc_i,
  output logic       ext_o,
  output logic       nested_o,
  output logic       miss_o,
  output logic       perm_o,
  output logic       bad_o,
  output logic       dacc_o
);
  logic fault;

  always_comb begin
    ext_o    = HAS_EIC && (cause_i == CAUSE_EXT);
    nested_o = HAS_MMU && eh_i;
    // TLB-class flags only exist with an MMU and only for noninterrupt causes
    fault    = HAS_MMU && (cause_i == CAUSE_EXC);
    miss_o   = fault && miss_i;
    perm_o   = fault && perm_i;
    bad_o    = fault && bad_i;
    dacc_o   = fault && dacc_i;
  end
endmodule

// File: rtl/exc_status_next.sv
module exc_status_next
  import exc_pkg::*;
#(
  parameter bit HAS_MMU = 1'b1,
  parameter bit HAS_SRS = 1'b1
) (
  input  stat_t           cur_i,
  input  logic            ext_i,
  input  logic            nested_i,
  input  logic [RS_W-1:0] rrs_i,
  input  logic            nmi_i,
  input  logic [IL_W-1:0] il_i,
  output stat_t           stat_o,
  output stat_t           sst_o,
  output logic            wr_est_o,
  output logic            wr_sst_o
);
  logic rrs_zero;

  always_comb begin
    rrs_zero = (rrs_i == '0);

    stat_o     = cur_i;
    stat_o.pie = 1'b0;
    stat_o.u   = 1'b0;
    stat_o.eh  = HAS_MMU;
    if (ext_i) begin
      stat_o.ih   = 1'b1;
      stat_o.nmi  = nmi_i;
      stat_o.il   = il_i;
      stat_o.rsie = 1'b0;
      stat_o.crs  = rrs_i;
      stat_o.prs  = cur_i.crs;
    end

    sst_o     = cur_i;
    sst_o.srs = HAS_SRS && (rrs_i != cur_i.crs);

    wr_est_o = !nested_i && (!ext_i || rrs_zero);
    wr_sst_o = HAS_SRS && ext_i && !rrs_zero;
  end
endmodule

// File: rtl/exc_mmu_next.sv
module exc_mmu_next
  import exc_pkg::*;
(
  input  logic       ext_i,
  input  logic       nested_i,
  input  logic       miss_i,
  input  logic       perm_i,
  input  logic       bad_i,
  input  logic       dacc_i,
  input  logic [3:0] tm_q_i,
  output logic [3:0] tm_d_o,
  output logic       vpn_ld_o
);
  always_comb begin
    tm_d_o = tm_q_i;
    if (!ext_i) begin
      tm_d_o[TM_DBL] = miss_i && nested_i;
      // first-exception diagnostics survive a nested entry
      if (!nested_i) begin
        tm_d_o[TM_D]    = dacc_i;
        tm_d_o[TM_PERM] = perm_i;
        tm_d_o[TM_BAD]  = bad_i;
      end
    end
    vpn_ld_o = !ext_i && !nested_i && (miss_i || perm_i);
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_pkg::*;
#(
  parameter bit               HAS_MMU  = 1'b1,
  parameter bit               HAS_SRS  = 1'b1,
  parameter bit               HAS_EIC  = 1'b1,
  parameter int               ADDR_W   = 32,
  parameter int               VPN_W    = 20,
  parameter logic [ADDR_W-1:0] GEN_VEC  = 'h20,
  parameter logic [ADDR_W-1:0] FAST_VEC = 'h100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exc_i,
  input  logic [1:0]        cause_i,
  input  logic              tlb_miss_i,
  input  logic              tlb_perm_i,
  input  logic              bad_addr_i,
  input  logic              data_acc_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic [VPN_W-1:0]  fault_vpn_i,
  input  logic [ADDR_W-1:0] ret_addr_i,
  input  logic [ADDR_W-1:0] eic_handler_i,
  input  logic [RS_W-1:0]   eic_rrs_i,
  input  logic              eic_nmi_i,
  input  logic [IL_W-1:0]   eic_il_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [STAT_W-1:0] status_o,
  output logic [STAT_W-1:0] estatus_o,
  output logic [STAT_W-1:0] sstatus_o,
  output logic [ADDR_W-1:0] ea_o,
  output logic [VPN_W-1:0]  pte_vpn_o,
  output logic [3:0]        tlbmisc_o
);
  stat_t           cur;
  stat_t           stat_d, sst_d;
  stat_t           stat_q, est_q;
  logic            ext, nested, miss, perm, bad, dacc;
  logic            wr_est, wr_sst;
  logic [RS_W-1:0] rrs;
  logic [ADDR_W-1:0] pc_q, pc_d, ea_q;

  assign cur = strip_stat(stat_t'(status_i), HAS_MMU, HAS_SRS, HAS_EIC);
  assign rrs = HAS_SRS ? eic_rrs_i : '0;

  exc_cause_decode #(.HAS_MMU(HAS_MMU), .HAS_EIC(HAS_EIC)) u_dec (
    .cause_i (cause_i),
    .eh_i    (cur.eh),
    .miss_i  (tlb_miss_i),
    .perm_i  (tlb_perm_i),
    .bad_i   (bad_addr_i),
    .dacc_i  (data_acc_i),
    .ext_o   (ext),
    .nested_o(nested),
    .miss_o  (miss),
    .perm_o  (perm),
    .bad_o   (bad),
    .dacc_o  (dacc)
  );

  exc_status_next #(.HAS_MMU(HAS_MMU), .HAS_SRS(HAS_SRS)) u_stat (
    .cur_i   (cur),
    .ext_i   (ext),
    .nested_i(nested),
    .rrs_i   (rrs),
    .nmi_i   (eic_nmi_i),
    .il_i    (eic_il_i),
    .stat_o  (stat_d),
    .sst_o   (sst_d),
    .wr_est_o(wr_est),
    .wr_sst_o(wr_sst)
  );

  always_comb begin
    if (ext)                  pc_d = eic_handler_i;
    else if (miss && !nested) pc_d = FAST_VEC;
    else                      pc_d = GEN_VEC;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      stat_q <= '0;
      est_q  <= '0;
      ea_q   <= '0;
    end else if (exc_i) begin
      pc_q   <= pc_d;
      stat_q <= stat_d;
      if (wr_est) begin
        est_q <= cur;
        ea_q  <= ret_addr_i;
      end
    end
  end

  if (HAS_SRS) begin : g_sst
    stat_t sst_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               sst_q <= '0;
      else if (exc_i && wr_sst)  sst_q <= sst_d;
    end
    assign sstatus_o = sst_q;
  end else begin : g_no_sst
    assign sstatus_o = '0;
  end

  if (HAS_MMU) begin : g_mmu
    logic [3:0]       tm_q, tm_d;
    logic [VPN_W-1:0] vpn_q;
    logic             vpn_ld;
    exc_mmu_next u_mmu (
      .ext_i   (ext),
      .nested_i(nested),
      .miss_i  (miss),
      .perm_i  (perm),
      .bad_i   (bad),
      .dacc_i  (dacc),
      .tm_q_i  (tm_q),
      .tm_d_o  (tm_d),
      .vpn_ld_o(vpn_ld)
    );
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tm_q  <= '0;
        vpn_q <= '0;
      end else if (exc_i) begin
        tm_q <= tm_d;
        if (vpn_ld) vpn_q <= fault_vpn_i;
      end
    end
    assign tlbmisc_o = tm_q;
    assign pte_vpn_o = vpn_q;
  end else begin : g_no_mmu
    assign tlbmisc_o = '0;
    assign pte_vpn_o = '0;
  end

  assign pc_o      = pc_q;
  assign status_o  = stat_q;
  assign estatus_o = est_q;
  assign ea_o      = ea_q;

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_i |=> $stable(pc_o) && $stable(status_o) && $stable(estatus_o)
               && $stable(ea_o) && $stable(tlbmisc_o) && $stable(pte_vpn_o));

  p_entry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_i |=> !stat_q.pie && !stat_q.u && (stat_q.eh == HAS_MMU));

  p_vec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_i && !ext |=> (pc_o == GEN_VEC) || (pc_o == FAST_VEC));

  p_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_i && nested |=> $stable(estatus_o) && $stable(ea_o) && $stable(pte_vpn_o));

  p_dbl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_i && !ext && !(miss && nested) |=> !tlbmisc_o[TM_DBL]);

  p_ext_pc_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_i && ext |=> pc_o == $past(eic_handler_i));

  p_ext_keep_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_i && ext |=> $stable(tlbmisc_o) && $stable(pte_vpn_o));
endmodule

// File: tb/exc_entry_unit_bench.sv
`timescale 1ns/1ps
module exc_entry_unit_bench;
  import exc_pkg::*;

  localparam logic [31:0] GV = 32'h20;
  localparam logic [31:0] FV = 32'h100;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic        exc;
  logic [1:0]  cause;
  logic        miss, perm, bad, dacc;
  stat_t       st;
  logic [19:0] fvpn;
  logic [31:0] ret, hnd;
  logic [5:0]  rrs;
  logic        nmi;
  logic [5:0]  il;

  logic [31:0]     pc_w[2];
  logic [STAT_W-1:0] stat_w[2], est_w[2], sst_w[2];
  logic [31:0]     ea_w[2];
  logic [19:0]     vpn_w[2];
  logic [3:0]      tm_w[2];

  exc_entry_unit u_exc_entry_unit (
    .clk_i(clk), .rst_ni(rst_ni), .exc_i(exc), .cause_i(cause),
    .tlb_miss_i(miss), .tlb_perm_i(perm), .bad_addr_i(bad), .data_acc_i(dacc),
    .status_i(st), .fault_vpn_i(fvpn), .ret_addr_i(ret), .eic_handler_i(hnd),
    .eic_rrs_i(rrs), .eic_nmi_i(nmi), .eic_il_i(il),
    .pc_o(pc_w[0]), .status_o(stat_w[0]), .estatus_o(est_w[0]), .sstatus_o(sst_w[0]),
    .ea_o(ea_w[0]), .pte_vpn_o(vpn_w[0]), .tlbmisc_o(tm_w[0])
  );

  exc_entry_unit #(.HAS_MMU(1'b0), .HAS_SRS(1'b0), .HAS_EIC(1'b0)) u_exc_entry_unit_bare (
    .clk_i(clk), .rst_ni(rst_ni), .exc_i(exc), .cause_i(cause),
    .tlb_miss_i(miss), .tlb_perm_i(perm), .bad_addr_i(bad), .data_acc_i(dacc),
    .status_i(st), .fault_vpn_i(fvpn), .ret_addr_i(ret), .eic_handler_i(hnd),
    .eic_rrs_i(rrs), .eic_nmi_i(nmi), .eic_il_i(il),
    .pc_o(pc_w[1]), .status_o(stat_w[1]), .estatus_o(est_w[1]), .sstatus_o(sst_w[1]),
    .ea_o(ea_w[1]), .pte_vpn_o(vpn_w[1]), .tlbmisc_o(tm_w[1])
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  stat_t       e_st[2], e_est[2], e_sst[2];
  logic [31:0] e_pc[2], e_ea[2];
  logic [19:0] e_vpn[2];
  logic [3:0]  e_tm[2];
  logic        last_ext, last_nest;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model(input int k);
    bit f = (k == 0);
    stat_t c, n;
    logic ext, nest, m, p, b, d;
    logic [5:0] r;
    c = st;
    if (!f) begin
      c = '0;
      c.pie = st.pie;
    end
    ext  = f && (cause == 2'd2);
    nest = f && c.eh;
    m = f && (cause == 2'd0) && miss;
    p = f && (cause == 2'd0) && perm;
    b = f && (cause == 2'd0) && bad;
    d = f && (cause == 2'd0) && dacc;
    r = f ? rrs : 6'd0;
    e_pc[k] = ext ? hnd : ((m && !nest) ? FV : GV);
    n = c;
    n.pie = 1'b0;
    n.u = 1'b0;
    n.eh = f;
    if (ext) begin
      n.ih = 1'b1; n.nmi = nmi; n.il = il; n.rsie = 1'b0;
      n.crs = r; n.prs = c.crs;
    end
    e_st[k] = n;
    if (!nest && (!ext || r == 0)) begin
      e_est[k] = c;
      e_ea[k]  = ret;
    end
    if (ext && r != 0) begin
      e_sst[k] = c;
      e_sst[k].srs = (r != c.crs);
    end
    if (f && !ext) begin
      e_tm[k][2] = m && nest;
      if (!nest) begin
        e_tm[k][3] = d; e_tm[k][1] = p; e_tm[k][0] = b;
        if (m || p) e_vpn[k] = fvpn;
      end
    end
    if (k == 0) begin
      last_ext = ext;
      last_nest = nest;
    end
  endtask

  task automatic compare(input bit hold);
    for (int k = 0; k < 2; k++) begin
      string t;
      stat_t a;
      a = stat_t'(stat_w[k]);
      if (k == 1)    t = "R13";
      else if (hold) t = "R2";
      else           t = "";
      chk((t != "") ? t : (last_ext ? "R10" : "R4"), 64'(pc_w[k]), 64'(e_pc[k]));
      chk((t != "") ? t : "R3", 64'({a.pie, a.u, a.eh}), 64'({e_st[k].pie, e_st[k].u, e_st[k].eh}));
      chk((t != "") ? t : (last_ext ? "R10" : "R12"), 64'(stat_w[k]), 64'(e_st[k]));
      chk((t != "") ? t : (last_nest ? "R5" : (last_ext ? "R11" : "R6")), 64'(est_w[k]), 64'(e_est[k]));
      chk((t != "") ? t : (last_nest ? "R5" : (last_ext ? "R11" : "R6")), 64'(ea_w[k]), 64'(e_ea[k]));
      chk((t != "") ? t : "R11", 64'(sst_w[k]), 64'(e_sst[k]));
      chk((t != "") ? t : (last_ext ? "R12" : "R9"), 64'(vpn_w[k]), 64'(e_vpn[k]));
      chk((t != "") ? t : (last_ext ? "R12" : "R7"), 64'(tm_w[k]), 64'(e_tm[k]));
      chk((t != "") ? t : "R8", 64'(tm_w[k][2]), 64'(e_tm[k][2]));
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected <100000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin
    int step = 0;
    exc = 0; cause = 0; miss = 0; perm = 0; bad = 0; dacc = 0;
    st = '0; fvpn = '0; ret = '0; hnd = '0; rrs = '0; nmi = 0; il = '0;
    last_ext = 0; last_nest = 0;
    for (int k = 0; k < 2; k++) begin
      e_st[k] = '0; e_est[k] = '0; e_sst[k] = '0;
      e_pc[k] = '0; e_ea[k] = '0; e_vpn[k] = '0; e_tm[k] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    for (int k = 0; k < 2; k++) begin
      chk("R1", 64'(pc_w[k]), 64'(0));
      chk("R1", 64'(stat_w[k]), 64'(0));
      chk("R1", 64'(est_w[k]), 64'(0));
      chk("R1", 64'(sst_w[k]), 64'(0));
      chk("R1", 64'(ea_w[k]), 64'(0));
      chk("R1", 64'(vpn_w[k]), 64'(0));
      chk("R1", 64'(tm_w[k]), 64'(0));
    end
    rst_ni = 1'b1;
    @(negedge clk);

    for (int e = 0; e < 2; e++)
      for (int c = 0; c < 3; c++)
        for (int fl = 0; fl < 16; fl++)
          for (int r = 0; r < 3; r++) begin
            logic [5:0] crs_v;
            step++;
            crs_v = 6'(step % 4);
            cause = 2'(c);
            {miss, perm, bad, dacc} = 4'(fl);
            st = '0;
            st.pie = 1'b1; st.u = 1'b1; st.eh = 1'(e);
            st.ih = step[0]; st.nmi = step[1]; st.srs = step[2];
            st.il = 6'(step * 5); st.prs = 6'(step * 3); st.crs = crs_v;
            st.rsie = 1'b1;
            rrs = (r == 0) ? 6'd0 : ((r == 1) ? crs_v : 6'(crs_v + 7));
            nmi = ~step[0];
            il = 6'(step + 11);
            fvpn = 20'(step * 97 + 1);
            ret = 32'h1000 + 32'(step * 4);
            hnd = 32'h8000_0000 | 32'(step * 8);
            exc = 1'b1;
            model(0);
            model(1);
            @(posedge clk);
            @(negedge clk);
            exc = 1'b0;
            compare(1'b0);
            // R2: idle cycle with disturbed inputs
            cause = 2'(~c); {miss, perm, bad, dacc} = 4'hf;
            st = ~st; ret = ~ret; hnd = ~hnd; fvpn = ~fvpn; rrs = ~rrs;
            @(posedge clk);
            @(negedge clk);
            compare(1'b1);
          end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule